// File: doc/BRIEF.md
# Windowed Watchdog Timer with Boot-Time Configuration

This block is a watchdog counter driven by a slow oscillator tick. The slow clock reaches the block as a one-cycle enable pulse in the system clock domain. On the first clock after reset is released, the block captures an 8-bit configuration byte. That byte decides four things: whether the watchdog runs, how long it runs before it overflows, how much of the period forms the window in which software may refresh it, and whether the slow clock is locked on. The byte is never sampled again until the next reset.

Software refreshes the watchdog by writing a key byte. The write is accepted only while the window is open, which is the final part of the period. A write outside the window, a write with the wrong key, and an overflow each raise a one-cycle reset request. A configuration that is not allowed sets an error flag and raises one reset request. When the lock bit is clear, the counter receives no ticks while software stops the oscillator or while the chip is in a low-power mode.

Top module: `optbyte_watchdog`

## Requirements
- R1: The configuration byte is decoded as follows. Bit 0 is the oscillator lock. Bits 3:1 are the period code `c`. Bit 4 is the enable. Bits 6:5 are the window code `w`. Bit 7 is reserved and must be 0. The byte is captured on the first rising clock edge after `rstN` goes high. Later changes to `optByte` have no effect until the next reset.
- R2: While reset is asserted, and right after it is released, `resetReq`, `cfgErr` and `countVal` are 0.
- R3: With the enable bit at 0, `countVal` stays 0 and refresh writes never raise `resetReq`.
- R4: When enabled, each permitted `oscTick` increments `countVal`. The period is P = 2^(BASE_EXP+c) ticks. A permitted tick at count P-1 sets `countVal` to 0 and raises `resetReq` for exactly one cycle.
- R5: A refresh is inside the window when `countVal` >= (P/4)*(3-w). Window codes 0, 1, 2 and 3 therefore leave 25%, 50%, 75% and 100% of the period open. A refresh outside the window raises `resetReq` on the next cycle.
- R6: The key is `REFRESH_KEY` (default 8'hAC). A refresh with any other data byte raises `resetReq`. Every refresh write on an enabled watchdog clears `countVal` to 0, whether it is valid or not.
- R7: A refresh write in the same cycle as a tick has priority. The counter clears, and the tick is dropped, including a tick that would have caused an overflow.
- R8: With the lock bit at 0, ticks are ignored while `oscStopReq` or `lowPower` is high. With the lock bit at 1, both inputs have no effect.
- R9: If reserved bit 7 is 1, or if c = 0 together with w = 0, then `cfgErr` rises one cycle after capture. `resetReq` pulses once, on the following cycle. The counter then stays at 0 and refresh writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| optByte | input | 8 | Configuration byte, captured once after reset |
| oscTick | input | 1 | One-cycle pulse per slow-oscillator period |
| refreshWr | input | 1 | Refresh write strobe |
| refreshData | input | 8 | Data byte of the refresh write |
| oscStopReq | input | 1 | Software request to stop the slow oscillator |
| lowPower | input | 1 | Chip is in a halt or stop mode |
| resetReq | output | 1 | Reset request pulse |
| cfgErr | output | 1 | Configuration byte is illegal |
| countVal | output | BASE_EXP+7 | Current watchdog count |

## Verification
The bench runs a reference model cycle by cycle. It checks `countVal`, `resetReq` and `cfgErr` on every clock against that model. Directed runs cover the following cases:
- An overflow with uninterrupted ticks, which confirms the period length.
- A refresh one count before the window opens and another exactly at its opening, which separates an off-by-one window edge from a correct one.
- A wrong key inside the window.
- A refresh that coincides with the overflow tick.
- Stop and low-power requests under both lock settings.
- Both illegal configuration forms.

Randomised configurations then mix sparse tick patterns, occasional refreshes and changes to the byte after capture. This mix shows whether the window limit follows both codes, not just one.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Field order mirrors the configuration byte, bit 7 down to bit 0.
  typedef struct packed {
    logic       rsvd;
    logic [1:0] win;
    logic       en;
    logic [2:0] code;
    logic       lock;
  } optCfg_t;

  // Strobes from control to the counter datapath.
  typedef struct packed {
    logic inc;
    logic clr;
  } cntCmd_t;
endpackage

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else if (cmd.clr) count <= '0;
    else if (cmd.inc) count <= count + 1'b1;
  end

  // Refresh/overflow clear and increment never requested together
  assert_cmd_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.inc && cmd.clr));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int         BASE_EXP    = 10,
  parameter logic [7:0] REFRESH_KEY = 8'hAC,
  parameter int         CNT_W       = BASE_EXP + 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       optByte,
  input  logic             oscTick,
  input  logic             refreshWr,
  input  logic [7:0]       refreshData,
  input  logic             oscStopReq,
  input  logic             lowPower,
  input  logic [CNT_W-1:0] count,
  output cntCmd_t          cmd,
  output logic             resetReq,
  output logic             cfgErr
);
  optCfg_t          cfgQ;
  logic             cfgLoaded;
  logic             errSent;
  logic [CNT_W:0]   perFull;
  logic [CNT_W:0]   quarter;
  logic [CNT_W+1:0] openFrom;
  logic [CNT_W-1:0] periodM1;
  logic active, gated, tickEn, refreshHit, windowOpen, badRefresh;
  logic atTop, overflow, errPulse, illegal;

  // Period, last count and start of the refresh window
  always_comb begin
    perFull  = {{CNT_W{1'b0}}, 1'b1} << (BASE_EXP + int'(cfgQ.code));
    periodM1 = CNT_W'(perFull - 1'b1);
    quarter  = perFull >> 2;
    unique case (cfgQ.win)
      2'd0:    openFrom = {1'b0, quarter} + {quarter, 1'b0};
      2'd1:    openFrom = {quarter, 1'b0};
      2'd2:    openFrom = {1'b0, quarter};
      default: openFrom = '0;
    endcase
  end

  always_comb begin
    active     = cfgLoaded && cfgQ.en && !cfgErr;
    gated      = !cfgQ.lock && (oscStopReq || lowPower);
    tickEn     = active && oscTick && !gated;
    refreshHit = active && refreshWr;
    windowOpen = {2'b00, count} >= openFrom;
    badRefresh = refreshHit && ((refreshData != REFRESH_KEY) || !windowOpen);
    atTop      = count == periodM1;
    overflow   = tickEn && atTop && !refreshHit;
    errPulse   = cfgErr && !errSent;
    cmd.clr    = refreshHit || overflow;
    cmd.inc    = tickEn && !atTop && !refreshHit;
    illegal    = optByte[7] || (optByte[3:1] == 3'd0 && optByte[6:5] == 2'd0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ      <= '0;
      cfgLoaded <= 1'b0;
      cfgErr    <= 1'b0;
      errSent   <= 1'b0;
      resetReq  <= 1'b0;
    end else begin
      if (!cfgLoaded) begin
        cfgQ      <= optCfg_t'(optByte);
        cfgErr    <= illegal;
        cfgLoaded <= 1'b1;
      end
      errSent  <= errSent || cfgErr;
      resetReq <= overflow || badRefresh || errPulse;
    end
  end

  assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoaded |=> $stable(cfgQ));
  assert_idle_when_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLoaded && !cfgQ.en) |-> (count == '0));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    count <= periodM1);
  assert_bad_key_R6: assert property (@(posedge clk) disable iff (!rstN)
    (refreshHit && refreshData != REFRESH_KEY) |=> resetReq);
  assert_gated_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (active && gated && !refreshWr) |=> $stable(count));
  assert_err_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (count == '0));
endmodule

// File: rtl/optbyte_watchdog.sv
module optbyte_watchdog
  import wdog_pkg::*;
#(
  parameter int         BASE_EXP    = 10,
  parameter logic [7:0] REFRESH_KEY = 8'hAC
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          optByte,
  input  logic                oscTick,
  input  logic                refreshWr,
  input  logic [7:0]          refreshData,
  input  logic                oscStopReq,
  input  logic                lowPower,
  output logic                resetReq,
  output logic                cfgErr,
  output logic [BASE_EXP+6:0] countVal
);
  localparam int CNT_W = BASE_EXP + 7;

  cntCmd_t cmd;

  wdog_ctrl #(.BASE_EXP(BASE_EXP), .REFRESH_KEY(REFRESH_KEY), .CNT_W(CNT_W)) ctrl (
    .clk(clk), .rstN(rstN), .optByte(optByte), .oscTick(oscTick),
    .refreshWr(refreshWr), .refreshData(refreshData), .oscStopReq(oscStopReq),
    .lowPower(lowPower), .count(countVal), .cmd(cmd), .resetReq(resetReq),
    .cfgErr(cfgErr)
  );

  wdog_count #(.CNT_W(CNT_W)) dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .count(countVal)
  );
endmodule

// File: tb/optbyte_watchdog_test.sv
`timescale 1ns/1ps
module optbyte_watchdog_test;
  localparam int BE = 2;
  localparam int CW = BE + 7;
  localparam logic [7:0] KEY = 8'hAC;

  logic clk = 0, rstN = 0;
  logic [7:0] optByte = 0, refreshData = 0;
  logic oscTick = 0, refreshWr = 0, oscStopReq = 0, lowPower = 0;
  logic resetReq, cfgErr;
  logic [CW-1:0] countVal;

  optbyte_watchdog #(.BASE_EXP(BE), .REFRESH_KEY(KEY)) uut (
    .clk(clk), .rstN(rstN), .optByte(optByte), .oscTick(oscTick),
    .refreshWr(refreshWr), .refreshData(refreshData), .oscStopReq(oscStopReq),
    .lowPower(lowPower), .resetReq(resetReq), .cfgErr(cfgErr), .countVal(countVal)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  // reference model state
  int mCnt = 0; bit mReq = 0, mErr = 0, mSent = 0, mLoaded = 0;
  logic [7:0] mCfg = 0;

  function automatic int periodOf(logic [2:0] c);
    return 1 << (BE + c);
  endfunction
  function automatic int openFrom(logic [2:0] c, logic [1:0] w);
    return (periodOf(c) / 4) * (3 - w);
  endfunction

  task automatic modelEdge();
    bit en, tk, hit, bad, ovf, pulse;
    int p;
    if (!rstN) begin
      mCnt = 0; mReq = 0; mErr = 0; mSent = 0; mLoaded = 0; mCfg = 0;
      return;
    end
    if (!mLoaded) begin
      mCfg = optByte; mLoaded = 1; mReq = 0;
      mErr = optByte[7] || (optByte[3:1] == 0 && optByte[6:5] == 0);
      return;
    end
    p   = periodOf(mCfg[3:1]);
    en  = mCfg[4] && !mErr;
    tk  = en && oscTick && !(!mCfg[0] && (oscStopReq || lowPower));
    hit = en && refreshWr;
    bad = hit && (refreshData != KEY || mCnt < openFrom(mCfg[3:1], mCfg[6:5]));
    ovf = tk && mCnt == p - 1 && !hit;
    pulse = mErr && !mSent;
    mSent = mSent || mErr;
    mReq = ovf || bad || pulse;
    if (hit || ovf) mCnt = 0;
    else if (tk) mCnt = mCnt + 1;
  endtask

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(tag, int'(countVal), mCnt, "countVal");
    check(tag, int'(resetReq), int'(mReq), "resetReq");
    check(tag, int'(cfgErr), int'(mErr), "cfgErr");
  endtask

  task automatic doReset(logic [7:0] opt);
    refreshWr = 0; oscTick = 0; oscStopReq = 0; lowPower = 0;
    rstN = 0; optByte = opt;
    step("R2"); step("R2");
    rstN = 1;
    step("R1");
  endtask

  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) begin oscTick = 1; step(tag); end
    oscTick = 0;
  endtask

  task automatic refresh(logic [7:0] d, string tag);
    refreshWr = 1; refreshData = d; step(tag); refreshWr = 0; step(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R2 reset state, R4 overflow with code 0 window 3 (P=4)
    doReset(8'h71);
    ticks(9, "R4");
    // R5 window edge: code 0, window 1 -> opens at count 2
    doReset(8'h31);
    ticks(1, "R5"); refresh(KEY, "R5");   // count 1: early
    ticks(2, "R5"); refresh(KEY, "R5");   // count 2: inside
    // R6 wrong key inside window
    ticks(3, "R6"); refresh(8'h55, "R6");
    // R7 refresh coincident with overflow tick
    ticks(3, "R7"); oscTick = 1; refreshWr = 1; refreshData = KEY; step("R7");
    oscTick = 0; refreshWr = 0; step("R7");
    // R8 gating with lock 0 and lock 1
    doReset(8'h72);
    lowPower = 1; ticks(5, "R8"); lowPower = 0;
    oscStopReq = 1; ticks(5, "R8"); oscStopReq = 0; ticks(3, "R8");
    doReset(8'h73);
    lowPower = 1; oscStopReq = 1; ticks(6, "R8"); lowPower = 0; oscStopReq = 0;
    // R3 disabled watchdog; R1 byte changed after capture
    doReset(8'h62);
    optByte = 8'h73; ticks(10, "R3"); refresh(8'h00, "R3"); refresh(KEY, "R1");
    // R9 illegal forms
    doReset(8'hF3); ticks(4, "R9"); refresh(8'h00, "R9");
    doReset(8'h11); ticks(4, "R9");
    // randomised mix
    for (int r = 0; r < 48; r++) begin
      logic [7:0] opt;
      opt = 8'($urandom);
      if ($urandom % 8 != 0) opt[7] = 0;
      if ($urandom % 4 != 0) opt[4] = 1;
      doReset(opt);
      for (int j = 0; j < 600; j++) begin
        oscTick     = ($urandom % 4) != 0;
        refreshWr   = ($urandom % 48) == 0;
        refreshData = ($urandom % 8 == 0) ? 8'($urandom) : KEY;
        lowPower    = ($urandom % 16) == 0;
        oscStopReq  = ($urandom % 20) == 0;
        if ($urandom % 100 == 0) optByte = 8'($urandom);
        step("R4 R5 R6 R8");
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule